// File: doc/BRIEF.md
# Unaligned Load/Store Merge Unit

This block is the data-alignment stage of a 64-bit load/store pipeline whose memory is big-endian while the read and write buses are little-endian by lane. Each accepted operation carries an operation code, a virtual address, the current value of the general register involved, and the doubleword the memory returned for the address with its low three bits cleared. One clock edge later the block presents either a register writeback value or a store image: write data placed on the correct byte lanes, byte enables and the access address.

Besides the plain byte, halfword, word and doubleword transfers, the block handles the high-part and low-part partial transfers used to move unaligned words and doublewords in two instructions. The partial loads merge memory bytes into the old register value. The partial stores are read-modify-write: the memory image that was read is merged with register bytes and the whole word or doubleword is written back. Address translation, fault detection and the memory are outside; a fault flag from outside cancels the operation in the cycle it is presented.

Top module: `lsu_merge_unit`

## Requirements
- R1: While reset is asserted and until the first accepted operation, every output is zero.
- R2: Operation codes: 0 signed byte load, 1 unsigned byte load, 2 signed half load, 3 unsigned half load, 4 signed word load, 5 unsigned word load, 6 doubleword load, 7 word high-part load, 8 word low-part load, 9 doubleword high-part load, 10 doubleword low-part load, 11 byte store, 12 half store, 13 word store, 14 doubleword store, 15 word high-part store, 16 word low-part store, 17 doubleword high-part store, 18 doubleword low-part store. An operation with op_valid high and exc_in low raises rf_we (codes 0 to 10) or mem_we (codes 11 to 18) on the next clock edge for one cycle; op_valid low or codes 19 to 31 raise neither.
- R3: Lane k (bits 8k+7:8k) of mem_rdata holds the byte at base+k, base being the address with its low three bits zero; a value of n bytes at offset o takes its most significant byte from lane o. Signed loads sign-extend from bit 8n-1, unsigned loads zero-extend.
- R4: A plain store of n bytes at offset o puts register byte n-1-j (counting from the least significant) on lane o+j, sets mem_be bit o+j for j below n, leaves all other lanes zero, and gives mem_addr equal to vaddr.
- R5: Word high-part load with o = vaddr[1:0]: the word is shifted left by 8*o, the register keeps its bits below 8*o, and the 64-bit result is sign-extended from bit 31.
- R6: Word low-part load with s = 8*(o+1): the word shifted right by 32-s, sign-extended from 32 bits, replaces the register bits selected by the low s bits mask sign-extended from 32 bits; other register bits stay.
- R7: Doubleword high-part and low-part loads follow R5 and R6 with o = vaddr[2:0], 64-bit data and no sign extension.
- R8: Word high-part store: with d = 0xFFFFFFFF >> 8*o, memory bits outside d stay and the low register word shifted right by 8*o fills d. Word low-part store: with s = 8*(o+1) and d = 0xFFFFFFFF >> s, memory bits inside d stay and the register shifted left by 32-s fills the rest. The four lanes of the word are enabled.
- R9: Doubleword high-part and low-part stores follow R8 with o = vaddr[2:0] and 64-bit masks; all eight lanes are enabled.
- R10: Partial word operations use vaddr with bits 1:0 cleared as mem_addr; partial doubleword operations clear bits 2:0.
- R11: When exc_in is high with op_valid, neither rf_we nor mem_we rises for that operation, so a faulting read phase of a partial store issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code (R2) |
| vaddr | input | AW | Virtual address of the access |
| exc_in | input | 1 | Fault reported for this operation |
| reg_val | input | 64 | Old destination register value, or store source |
| mem_rdata | input | 64 | Doubleword read at the aligned address, lane k = byte base+k |
| rf_we | output | 1 | Register writeback enable |
| rf_wdata | output | 64 | Register writeback value |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 8 | Byte-lane write enables |
| mem_wdata | output | 64 | Store data on byte lanes |
| mem_addr | output | AW | Access address of the store |

## Verification
Acceptance of a new operation and emission of the previous one's registered result share every cycle, so the bench issues operations back to back, mixing loads and stores, and slips a faulting operation between two good ones. A reference model built on byte arrays predicts each cycle's enables and data, which are compared one edge later, so a suppression that leaks into a neighbour, or a neighbour's result lost to a fault, shows up as a mismatch on the exact cycle. Directed vectors with hand-computed constants cover each partial-transfer offset rule.

// File: rtl/lsu_merge_pkg.sv
package lsu_merge_pkg;

  localparam int XLEN  = 64;
  localparam int NLANE = XLEN / 8;

  typedef enum logic [4:0] {
    OP_LD_B    = 5'd0,  OP_LD_BU   = 5'd1,  OP_LD_H    = 5'd2,
    OP_LD_HU   = 5'd3,  OP_LD_W    = 5'd4,  OP_LD_WU   = 5'd5,
    OP_LD_D    = 5'd6,  OP_LD_WHI  = 5'd7,  OP_LD_WLO  = 5'd8,
    OP_LD_DHI  = 5'd9,  OP_LD_DLO  = 5'd10, OP_ST_B    = 5'd11,
    OP_ST_H    = 5'd12, OP_ST_W    = 5'd13, OP_ST_D    = 5'd14,
    OP_ST_WHI  = 5'd15, OP_ST_WLO  = 5'd16, OP_ST_DHI  = 5'd17,
    OP_ST_DLO  = 5'd18
  } lsu_op_e;

  typedef enum logic [1:0] {PART_NONE, PART_HI, PART_LO} part_e;

  typedef struct packed {
    logic       is_load;
    logic       is_store;
    part_e      part;
    logic       dbl;      // partial access spans a doubleword
    logic       sgn;      // sign-extend a plain load
    logic [3:0] nbytes;   // bytes moved by a plain access
  } op_cls_t;

  // Big-endian gather of n bytes starting at lane off.
  function automatic logic [63:0] lane_gather(input logic [63:0] bus,
                                              input logic [2:0]  off,
                                              input logic [3:0]  n);
    logic [63:0] acc;
    acc = '0;
    for (int k = 0; k < NLANE; k++) begin
      logic [2:0] idx;
      idx = off + 3'(k);
      if (4'(k) < n) acc = {acc[55:0], bus[{idx, 3'b000} +: 8]};
    end
    return acc;
  endfunction

  function automatic logic [63:0] sext_bytes(input logic [63:0] v,
                                             input logic [3:0]  n);
    case (n)
      4'd1:    return {{56{v[7]}},  v[7:0]};
      4'd2:    return {{48{v[15]}}, v[15:0]};
      4'd4:    return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [63:0] merge_whi_ld(input logic [63:0] r,
                                               input logic [31:0] m,
                                               input logic [1:0]  o);
    logic [6:0]  sh;
    logic [63:0] t;
    sh = {2'b00, o, 3'b000};
    t  = (r & ~(~64'd0 << sh)) | ({32'd0, m} << sh);
    return {{32{t[31]}}, t[31:0]};
  endfunction

  function automatic logic [63:0] merge_wlo_ld(input logic [63:0] r,
                                               input logic [31:0] m,
                                               input logic [1:0]  o);
    logic [6:0]  sh;
    logic [31:0] d32, k32;
    sh  = {2'b00, o, 3'b000} + 7'd8;
    d32 = m >> (7'd32 - sh);
    k32 = 32'hFFFF_FFFF >> (7'd32 - sh);
    return (r & ~{{32{k32[31]}}, k32}) | {{32{d32[31]}}, d32};
  endfunction

  function automatic logic [63:0] merge_dhi_ld(input logic [63:0] r,
                                               input logic [63:0] m,
                                               input logic [2:0]  o);
    logic [6:0] sh;
    sh = {1'b0, o, 3'b000};
    return (r & ~(~64'd0 << sh)) | (m << sh);
  endfunction

  function automatic logic [63:0] merge_dlo_ld(input logic [63:0] r,
                                               input logic [63:0] m,
                                               input logic [2:0]  o);
    logic [6:0]  sh;
    logic [63:0] k;
    sh = {1'b0, o, 3'b000} + 7'd8;
    k  = ~64'd0 >> (7'd64 - sh);
    return (r & ~k) | (m >> (7'd64 - sh));
  endfunction

  function automatic logic [31:0] merge_whi_st(input logic [31:0] m,
                                               input logic [63:0] r,
                                               input logic [1:0]  o);
    logic [6:0]  sh;
    logic [31:0] dm;
    sh = {2'b00, o, 3'b000};
    dm = 32'hFFFF_FFFF >> sh;
    return (m & ~dm) | (r[31:0] >> sh);
  endfunction

  function automatic logic [31:0] merge_wlo_st(input logic [31:0] m,
                                               input logic [63:0] r,
                                               input logic [1:0]  o);
    logic [6:0]  sh;
    logic [31:0] dm;
    sh = {2'b00, o, 3'b000} + 7'd8;
    dm = 32'hFFFF_FFFF >> sh;
    return (m & dm) | (r[31:0] << (7'd32 - sh));
  endfunction

  function automatic logic [63:0] merge_dhi_st(input logic [63:0] m,
                                               input logic [63:0] r,
                                               input logic [2:0]  o);
    logic [6:0]  sh;
    logic [63:0] dm;
    sh = {1'b0, o, 3'b000};
    dm = ~64'd0 >> sh;
    return (m & ~dm) | (r >> sh);
  endfunction

  function automatic logic [63:0] merge_dlo_st(input logic [63:0] m,
                                               input logic [63:0] r,
                                               input logic [2:0]  o);
    logic [6:0]  sh;
    logic [63:0] dm;
    sh = {1'b0, o, 3'b000} + 7'd8;
    dm = ~64'd0 >> sh;
    return (m & dm) | (r << (7'd64 - sh));
  endfunction

endpackage

// File: rtl/lsu_op_decode.sv
module lsu_op_decode
  import lsu_merge_pkg::*;
(
  input  logic [4:0] op_code,
  output op_cls_t    cls
);
  always_comb begin
    cls = '0;
    case (lsu_op_e'(op_code))
      OP_LD_B:   begin cls.is_load = 1'b1; cls.sgn = 1'b1; cls.nbytes = 4'd1; end
      OP_LD_BU:  begin cls.is_load = 1'b1; cls.nbytes = 4'd1; end
      OP_LD_H:   begin cls.is_load = 1'b1; cls.sgn = 1'b1; cls.nbytes = 4'd2; end
      OP_LD_HU:  begin cls.is_load = 1'b1; cls.nbytes = 4'd2; end
      OP_LD_W:   begin cls.is_load = 1'b1; cls.sgn = 1'b1; cls.nbytes = 4'd4; end
      OP_LD_WU:  begin cls.is_load = 1'b1; cls.nbytes = 4'd4; end
      OP_LD_D:   begin cls.is_load = 1'b1; cls.nbytes = 4'd8; end
      OP_LD_WHI: begin cls.is_load = 1'b1; cls.part = PART_HI; cls.nbytes = 4'd4; end
      OP_LD_WLO: begin cls.is_load = 1'b1; cls.part = PART_LO; cls.nbytes = 4'd4; end
      OP_LD_DHI: begin cls.is_load = 1'b1; cls.part = PART_HI; cls.dbl = 1'b1; cls.nbytes = 4'd8; end
      OP_LD_DLO: begin cls.is_load = 1'b1; cls.part = PART_LO; cls.dbl = 1'b1; cls.nbytes = 4'd8; end
      OP_ST_B:   begin cls.is_store = 1'b1; cls.nbytes = 4'd1; end
      OP_ST_H:   begin cls.is_store = 1'b1; cls.nbytes = 4'd2; end
      OP_ST_W:   begin cls.is_store = 1'b1; cls.nbytes = 4'd4; end
      OP_ST_D:   begin cls.is_store = 1'b1; cls.nbytes = 4'd8; end
      OP_ST_WHI: begin cls.is_store = 1'b1; cls.part = PART_HI; cls.nbytes = 4'd4; end
      OP_ST_WLO: begin cls.is_store = 1'b1; cls.part = PART_LO; cls.nbytes = 4'd4; end
      OP_ST_DHI: begin cls.is_store = 1'b1; cls.part = PART_HI; cls.dbl = 1'b1; cls.nbytes = 4'd8; end
      OP_ST_DLO: begin cls.is_store = 1'b1; cls.part = PART_LO; cls.dbl = 1'b1; cls.nbytes = 4'd8; end
      default:   cls = '0;
    endcase
  end
endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path
  import lsu_merge_pkg::*;
(
  input  op_cls_t     cls,
  input  logic [2:0]  off,
  input  logic [63:0] reg_val,
  input  logic [63:0] mem_rdata,
  output logic [63:0] ld_value
);
  logic [63:0] word_raw, dword, plain_raw, plain_ext;
  logic [31:0] word;

  always_comb begin
    word_raw  = lane_gather(mem_rdata, {off[2], 2'b00}, 4'd4);
    word      = word_raw[31:0];
    dword     = lane_gather(mem_rdata, 3'd0, 4'd8);
    plain_raw = lane_gather(mem_rdata, off, cls.nbytes);
    plain_ext = cls.sgn ? sext_bytes(plain_raw, cls.nbytes) : plain_raw;
    case (cls.part)
      PART_HI: ld_value = cls.dbl ? merge_dhi_ld(reg_val, dword, off)
                                  : merge_whi_ld(reg_val, word, off[1:0]);
      PART_LO: ld_value = cls.dbl ? merge_dlo_ld(reg_val, dword, off)
                                  : merge_wlo_ld(reg_val, word, off[1:0]);
      default: ld_value = plain_ext;
    endcase
  end
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
  import lsu_merge_pkg::*;
(
  input  op_cls_t     cls,
  input  logic [2:0]  off,
  input  logic [63:0] reg_val,
  input  logic [63:0] mem_rdata,
  output logic [63:0] st_wdata,
  output logic [7:0]  st_be
);
  logic [63:0] word_raw, dword, src_val;
  logic [31:0] word;
  logic [2:0]  base;
  logic [3:0]  cnt;

  always_comb begin
    word_raw = lane_gather(mem_rdata, {off[2], 2'b00}, 4'd4);
    word     = word_raw[31:0];
    dword    = lane_gather(mem_rdata, 3'd0, 4'd8);
    src_val  = reg_val;
    base     = off;
    cnt      = cls.nbytes;
    if (cls.part != PART_NONE) begin
      if (cls.dbl) begin
        base    = 3'd0;
        cnt     = 4'd8;
        src_val = (cls.part == PART_HI) ? merge_dhi_st(dword, reg_val, off)
                                        : merge_dlo_st(dword, reg_val, off);
      end else begin
        base    = {off[2], 2'b00};
        cnt     = 4'd4;
        src_val = {32'd0, (cls.part == PART_HI) ? merge_whi_st(word, reg_val, off[1:0])
                                                : merge_wlo_st(word, reg_val, off[1:0])};
      end
    end
  end

  // One scatter slice per byte lane: lane base+j receives value byte cnt-1-j.
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [3:0] rel;
    logic [2:0] sel;
    logic       hit;
    assign rel = 4'(k) - {1'b0, base};
    assign hit = (4'(k) >= {1'b0, base}) && (rel < cnt);
    assign sel = 3'(cnt - 4'd1 - rel);
    assign st_be[k]            = hit;
    assign st_wdata[8*k +: 8]  = hit ? src_val[{sel, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_merge_unit.sv
module lsu_merge_unit
  import lsu_merge_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    op_code,
  input  logic [AW-1:0] vaddr,
  input  logic          exc_in,
  input  logic [63:0]   reg_val,
  input  logic [63:0]   mem_rdata,
  output logic          rf_we,
  output logic [63:0]   rf_wdata,
  output logic          mem_we,
  output logic [7:0]    mem_be,
  output logic [63:0]   mem_wdata,
  output logic [AW-1:0] mem_addr
);
  op_cls_t       cls;
  logic [63:0]   ld_value, st_wdata;
  logic [7:0]    st_be;
  logic [AW-1:0] acc_addr;

  // Named events for the checker
  logic ev_load_fire, ev_store_fire, ev_squash;

  lsu_op_decode u_dec (.op_code(op_code), .cls(cls));

  lsu_load_path u_ld (
    .cls(cls), .off(vaddr[2:0]), .reg_val(reg_val),
    .mem_rdata(mem_rdata), .ld_value(ld_value)
  );

  lsu_store_path u_st (
    .cls(cls), .off(vaddr[2:0]), .reg_val(reg_val),
    .mem_rdata(mem_rdata), .st_wdata(st_wdata), .st_be(st_be)
  );

  always_comb begin
    acc_addr = vaddr;
    if (cls.part != PART_NONE) begin
      if (cls.dbl) acc_addr = {vaddr[AW-1:3], 3'b000};
      else         acc_addr = {vaddr[AW-1:2], 2'b00};
    end
  end

  assign ev_load_fire  = op_valid & ~exc_in & cls.is_load;
  assign ev_store_fire = op_valid & ~exc_in & cls.is_store;
  assign ev_squash     = op_valid & exc_in & (cls.is_load | cls.is_store);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_we     <= 1'b0;
      rf_wdata  <= '0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_wdata <= '0;
      mem_addr  <= '0;
    end else begin
      rf_we  <= ev_load_fire;
      mem_we <= ev_store_fire;
      if (ev_load_fire) rf_wdata <= ld_value;
      if (ev_store_fire) begin
        mem_wdata <= st_wdata;
        mem_be    <= st_be;
        mem_addr  <= acc_addr;
      end
    end
  end
endmodule

// File: rtl/lsu_merge_chk.sv
module lsu_merge_chk
  import lsu_merge_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [4:0]    op_code,
  input logic          exc_in,
  input logic          ev_squash,
  input logic          rf_we,
  input logic          mem_we,
  input logic [7:0]    mem_be,
  input logic [AW-1:0] mem_addr
);
  a_r2_load_go: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !exc_in && op_code <= OP_LD_DLO) |=> (rf_we && !mem_we));

  a_r2_store_go: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !exc_in && op_code >= OP_ST_B && op_code <= OP_ST_DLO)
      |=> (mem_we && !rf_we));

  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code > OP_ST_DLO) |=> (!rf_we && !mem_we));

  a_r11_squash: assert property (@(posedge clk) disable iff (!rst_n)
    ev_squash |=> (!rf_we && !mem_we));

  a_r4_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                $countones(mem_be) == 4 || $countones(mem_be) == 8));

  a_r10_word_part: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !exc_in && (op_code == OP_ST_WHI || op_code == OP_ST_WLO))
      |=> (mem_addr[1:0] == 2'b00 && (mem_be == 8'h0F || mem_be == 8'hF0)));

  a_r9_dbl_part: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !exc_in && (op_code == OP_ST_DHI || op_code == OP_ST_DLO))
      |=> (mem_addr[2:0] == 3'b000 && mem_be == 8'hFF));
endmodule

bind lsu_merge_unit lsu_merge_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .exc_in(exc_in), .ev_squash(ev_squash), .rf_we(rf_we), .mem_we(mem_we),
  .mem_be(mem_be), .mem_addr(mem_addr)
);

// File: tb/sim_lsu_merge_unit.sv
module sim_lsu_merge_unit;
  localparam int CLK_NS = 10;
  localparam int AW     = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [4:0]    op_code = '0;
  logic [AW-1:0] vaddr = '0;
  logic          exc_in = 1'b0;
  logic [63:0]   reg_val = '0;
  logic [63:0]   mem_rdata = '0;
  logic          rf_we, mem_we;
  logic [63:0]   rf_wdata, mem_wdata;
  logic [7:0]    mem_be;
  logic [AW-1:0] mem_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic          exp_rf_we, exp_mem_we;
  logic [63:0]   exp_rf, exp_wd;
  logic [7:0]    exp_be;
  logic [AW-1:0] exp_addr;
  string         exp_req;

  lsu_merge_unit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .vaddr(vaddr), .exc_in(exc_in), .reg_val(reg_val), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_addr(mem_addr)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Byte-level reference: builds the expected result lane by lane.
  task automatic model(input logic [4:0] op, input logic [AW-1:0] a,
                       input logic [63:0] r, input logic [63:0] rd,
                       input bit v, input bit x);
    logic [7:0] ln[8], rb[8], res[8], ol[8];
    int o8, o4, wb, n;
    bit sgn;
    o8 = int'(a[2:0]); o4 = int'(a[1:0]); wb = a[2] ? 4 : 0;
    for (int s = 0; s < 8; s++) begin
      ln[s] = rd[8*s +: 8]; rb[s] = r[8*s +: 8]; res[s] = rb[s]; ol[s] = 8'h00;
    end
    exp_be = 8'h00; exp_addr = a;
    n = 0; sgn = 0;
    case (op)
      5'd0: begin n = 1; sgn = 1; end
      5'd1: n = 1;
      5'd2: begin n = 2; sgn = 1; end
      5'd3: n = 2;
      5'd4: begin n = 4; sgn = 1; end
      5'd5: n = 4;
      5'd6: n = 8;
      5'd11: n = 1;
      5'd12: n = 2;
      5'd13: n = 4;
      5'd14: n = 8;
      default: n = 0;
    endcase
    exp_rf_we  = v && !x && op <= 5'd10;
    exp_mem_we = v && !x && op >= 5'd11 && op <= 5'd18;
    if (x) exp_req = "R11";
    else if (!v || op > 5'd18) exp_req = "R2";
    case (op)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6: begin
        for (int s = 0; s < 8; s++) res[s] = 8'h00;
        for (int j = 0; j < n; j++) res[n-1-j] = ln[o8+j];
        if (sgn && res[n-1][7]) for (int s = n; s < 8; s++) res[s] = 8'hFF;
        if (v && !x) exp_req = "R3";
      end
      5'd7: begin
        for (int p = 0; p <= 3 - o4; p++) res[3-p] = ln[wb+p+o4];
        for (int s = 4; s < 8; s++) res[s] = res[3][7] ? 8'hFF : 8'h00;
        if (v && !x) exp_req = "R5";
      end
      5'd8: begin
        for (int j = 0; j <= o4; j++) res[o4-j] = ln[wb+j];
        if (o4 == 3) for (int s = 4; s < 8; s++) res[s] = res[3][7] ? 8'hFF : 8'h00;
        if (v && !x) exp_req = "R6";
      end
      5'd9: begin
        for (int p = 0; p <= 7 - o8; p++) res[7-p] = ln[p+o8];
        if (v && !x) exp_req = "R7";
      end
      5'd10: begin
        for (int j = 0; j <= o8; j++) res[o8-j] = ln[j];
        if (v && !x) exp_req = "R7";
      end
      5'd11, 5'd12, 5'd13, 5'd14: begin
        for (int j = 0; j < n; j++) begin ol[o8+j] = rb[n-1-j]; exp_be[o8+j] = 1'b1; end
        if (v && !x) exp_req = "R4";
      end
      5'd15, 5'd16: begin
        for (int j = 0; j < 4; j++) begin
          if (op == 5'd15) ol[wb+j] = (j < o4) ? ln[wb+j] : rb[3-j+o4];
          else             ol[wb+j] = (j <= o4) ? rb[o4-j] : ln[wb+j];
          exp_be[wb+j] = 1'b1;
        end
        exp_addr = {a[AW-1:2], 2'b00};
        if (v && !x) exp_req = "R8";
      end
      5'd17, 5'd18: begin
        for (int j = 0; j < 8; j++) begin
          if (op == 5'd17) ol[j] = (j < o8) ? ln[j] : rb[7-j+o8];
          else             ol[j] = (j <= o8) ? rb[o8-j] : ln[j];
        end
        exp_be = 8'hFF;
        exp_addr = {a[AW-1:3], 3'b000};
        if (v && !x) exp_req = "R9";
      end
      default: ;
    endcase
    for (int s = 0; s < 8; s++) begin
      exp_rf[8*s +: 8] = res[s]; exp_wd[8*s +: 8] = ol[s];
    end
  endtask

  // Drive at a falling edge, let the rising edge capture, compare at the next fall.
  task automatic step(input logic [4:0] op, input logic [AW-1:0] a,
                      input logic [63:0] r, input logic [63:0] rd,
                      input bit v, input bit x);
    op_code = op; vaddr = a; reg_val = r; mem_rdata = rd; op_valid = v; exc_in = x;
    model(op, a, r, rd, v, x);
    @(negedge clk);
    chk(rf_we === exp_rf_we, exp_req, "rf_we", 64'(rf_we), 64'(exp_rf_we));
    chk(mem_we === exp_mem_we, exp_req, "mem_we", 64'(mem_we), 64'(exp_mem_we));
    if (exp_rf_we)
      chk(rf_wdata === exp_rf, exp_req, "rf_wdata", rf_wdata, exp_rf);
    if (exp_mem_we) begin
      chk(mem_wdata === exp_wd, exp_req, "mem_wdata", mem_wdata, exp_wd);
      chk(mem_be === exp_be, exp_req, "mem_be", 64'(mem_be), 64'(exp_be));
      chk(mem_addr === exp_addr, (exp_req == "R4") ? "R4" : "R10", "mem_addr",
          64'(mem_addr), 64'(exp_addr));
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd0;
    rd0 = 64'h8877_6655_4433_2211;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rf_we === 1'b0 && mem_we === 1'b0, "R1", "enables", {62'd0, rf_we, mem_we}, 64'd0);
    chk(rf_wdata === 64'd0, "R1", "rf_wdata", rf_wdata, 64'd0);
    chk(mem_wdata === 64'd0 && mem_be === 8'd0, "R1", "mem_wdata", mem_wdata, 64'd0);
    chk(mem_addr === '0, "R1", "mem_addr", 64'(mem_addr), 64'd0);
    rst_n = 1'b1;

    // Directed vectors with literal expectations
    step(5'd4, 32'h4, 64'd0, rd0, 1, 0);
    chk(rf_wdata === 64'h0000_0000_5566_7788, "R3", "word load lit", rf_wdata, 64'h0000_0000_5566_7788);
    step(5'd0, 32'h7, 64'd0, rd0, 1, 0);
    chk(rf_wdata === 64'hFFFF_FFFF_FFFF_FF88, "R3", "byte load lit", rf_wdata, 64'hFFFF_FFFF_FFFF_FF88);
    step(5'd7, 32'h1, 64'hAAAA_AAAA_BBCC_DDEE, rd0, 1, 0);
    chk(rf_wdata === 64'h0000_0000_2233_44EE, "R5", "whi load lit", rf_wdata, 64'h0000_0000_2233_44EE);
    step(5'd8, 32'h2, 64'hAAAA_AAAA_BBCC_DDEE, rd0, 1, 0);
    chk(rf_wdata === 64'hAAAA_AAAA_BB11_2233, "R6", "wlo load lit", rf_wdata, 64'hAAAA_AAAA_BB11_2233);
    step(5'd15, 32'h5, 64'hAAAA_AAAA_BBCC_DDEE, rd0, 1, 0);
    chk(mem_wdata === 64'hDDCC_BB55_0000_0000 && mem_be === 8'hF0, "R8", "whi store lit",
        mem_wdata, 64'hDDCC_BB55_0000_0000);
    chk(mem_addr === 32'h4, "R10", "whi store addr", 64'(mem_addr), 64'h4);
    step(5'd18, 32'h1, 64'h0102_0304_0506_0708, rd0, 1, 0);
    chk(mem_wdata === 64'h8877_6655_4433_0807, "R9", "dlo store lit", mem_wdata, 64'h8877_6655_4433_0807);
    step(5'd14, 32'h8, 64'h1234, rd0, 1, 1);
    chk(mem_we === 1'b0, "R11", "faulting store", 64'(mem_we), 64'd0);
    step(5'd25, 32'h0, 64'h1, rd0, 1, 0);
    chk(rf_we === 1'b0 && mem_we === 1'b0, "R2", "undefined code", {62'd0, rf_we, mem_we}, 64'd0);

    // Back-to-back mixed traffic with faults in between
    for (int i = 0; i < 600; i++) begin
      logic [4:0]    op;
      logic [AW-1:0] a;
      logic [63:0]   r, rd;
      bit            v, x;
      op = 5'($urandom_range(0, 20));
      a  = AW'($urandom);
      case (op)
        5'd2, 5'd3, 5'd12: a[0]   = 1'b0;
        5'd4, 5'd5, 5'd13: a[1:0] = 2'b00;
        5'd6, 5'd14:       a[2:0] = 3'b000;
        default: ;
      endcase
      r  = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      v  = ($urandom_range(0, 9) != 0);
      x  = ($urandom_range(0, 7) == 0);
      step(op, a, r, rd, v, x);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule